// File: doc/BRIEF.md
# Coin Credit Accumulator

This block is a synchronous finite-state machine that totals the coins a vending front end accepts until a fixed price of 35 cents is met. Each clock cycle it samples two single-cycle coin strobes, one for a 10-cent coin and one for a 25-cent coin, and it also samples a synchronous clear pulse. The running total is kept as one of six credit levels: 0, 10, 20, 25, 30 and 35 cents. The 35-cent level is final. Once the machine reaches it, further coins leave it there until the next clear.

A registered completion flag rises in the cycle after the coin that meets or exceeds the price. The current credit level is visible on a 3-bit code output, so surrounding logic or a debugger can follow the machine. The clear pulse also acts as the power-on reset. The block does not return change, does not reject coins, and does not support a configurable price.

Top module: `coin_credit_fsm`

## Requirements
- R1: While `clear` is high at a rising edge, the next state is code 000 (0 cents) and `done` is 0; the bench holds `clear` at start-up, so this is also the power-on state.
- R2: A 10-cent strobe alone moves the code 000→001, 001→010, 010→100, 011→101 and 100→101. The codes mean 0, 10, 20, 25, 30 and 35 cents for 000, 001, 010, 011, 100 and 101.
- R3: A 25-cent strobe moves the code 000→011, and moves any of 001, 010, 011 or 100 to 101.
- R4: In state 101, any coin strobe leaves the state at 101 and `done` at 1.
- R5: `clear` takes priority over both coin strobes in the same cycle, and the result is state 000.
- R6: When both coin strobes are high in one cycle, the machine acts as if only the 25-cent strobe were high.
- R7: With no strobe and no clear, both the state and `done` hold.
- R8: `done` is a registered output. It is 1 exactly when the state code is 101, so it rises in the cycle after the completing coin.
- R9: The state code never takes the unused values 110 or 111. If the register ever held one of them, the next edge without `clear` would move it to 101.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clear | input | 1 | Synchronous clear pulse, also used at power-on |
| dime | input | 1 | One-cycle strobe for a 10-cent coin |
| quarter | input | 1 | One-cycle strobe for a 25-cent coin |
| done | output | 1 | Registered flag, high once the price is met |
| stateCode | output | 3 | Current credit level code |

## Verification
The block has no configuration parameters, so the bench builds the single fixed design. A short walk through the stimulus table reaches every one of the six credit levels. Along the way it applies every legal dime move and every legal quarter move out of each non-final level. It also covers the cases where both coins arrive together, where a clear arrives together with a coin, and where coins keep arriving after the final level. Directed steps then hold the clear over several cycles while coins are presented, and check that the flag stays low.

// File: rtl/coin_pkg.sv
package coin_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    CR0  = 3'b000,
    CR10 = 3'b001,
    CR20 = 3'b010,
    CR25 = 3'b011,
    CR30 = 3'b100,
    CR35 = 3'b101
  } credit_e;

  typedef struct packed {
    logic clear;
    logic addDime;
    logic addQuarter;
  } coinStrobe_t;
endpackage

// File: rtl/coin_ctrl.sv
module coin_ctrl
  import coin_pkg::*;
(
  input  logic        clear,
  input  logic        dime,
  input  logic        quarter,
  output coinStrobe_t strobes
);
  // clear wins over coins (R5); a quarter masks a simultaneous dime (R6)
  always_comb begin
    strobes.clear      = clear;
    strobes.addQuarter = !clear && quarter;
    strobes.addDime    = !clear && dime && !quarter;
  end
endmodule

// File: rtl/coin_credit_dp.sv
module coin_credit_dp
  import coin_pkg::*;
(
  input  logic               clk,
  input  coinStrobe_t        strobes,
  output logic [STATE_W-1:0] stateCode,
  output logic               done
);
  logic [STATE_W-1:0] stateQ;
  logic [STATE_W-1:0] stateD;
  logic               doneQ;

  always_comb begin
    stateD = stateQ;
    if (strobes.clear) begin
      stateD = CR0;
    end else begin
      case (stateQ)
        CR0:  if (strobes.addQuarter) stateD = CR25;
              else if (strobes.addDime) stateD = CR10;
        CR10: if (strobes.addQuarter) stateD = CR35;
              else if (strobes.addDime) stateD = CR20;
        CR20: if (strobes.addQuarter) stateD = CR35;
              else if (strobes.addDime) stateD = CR30;
        CR25: if (strobes.addQuarter || strobes.addDime) stateD = CR35;
        CR30: if (strobes.addQuarter || strobes.addDime) stateD = CR35;
        default: stateD = CR35;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    stateQ <= stateD;
    doneQ  <= (stateD == CR35);
  end

  assign stateCode = stateQ;
  assign done      = doneQ;
endmodule

// File: rtl/coin_credit_fsm.sv
module coin_credit_fsm
  import coin_pkg::*;
(
  input  logic               clk,
  input  logic               clear,
  input  logic               dime,
  input  logic               quarter,
  output logic               done,
  output logic [STATE_W-1:0] stateCode
);
  coinStrobe_t strobes;

  coin_ctrl u_ctrl (
    .clear   (clear),
    .dime    (dime),
    .quarter (quarter),
    .strobes (strobes)
  );

  coin_credit_dp u_dp (
    .clk       (clk),
    .strobes   (strobes),
    .stateCode (stateCode),
    .done      (done)
  );
endmodule

// File: rtl/coin_credit_chk.sv
module coin_credit_chk (
  input logic       clk,
  input logic       clear,
  input logic       dime,
  input logic       quarter,
  input logic       done,
  input logic [2:0] stateCode
);
  assert_clear_to_zero_R1: assert property (@(posedge clk)
    clear |=> (stateCode == 3'b000 && !done));

  assert_dime_20_to_30_R2: assert property (@(posedge clk) disable iff (clear)
    (stateCode == 3'b010 && dime && !quarter) |=> stateCode == 3'b100);

  assert_quarter_from_zero_R3: assert property (@(posedge clk) disable iff (clear)
    (stateCode == 3'b000 && quarter) |=> stateCode == 3'b011);

  assert_final_sticks_R4: assert property (@(posedge clk) disable iff (clear)
    (stateCode == 3'b101) |=> (stateCode == 3'b101 && done));

  assert_both_as_quarter_R6: assert property (@(posedge clk) disable iff (clear)
    (stateCode == 3'b001 && dime && quarter) |=> stateCode == 3'b101);

  assert_idle_holds_R7: assert property (@(posedge clk) disable iff (clear)
    (!dime && !quarter) |=> ($stable(stateCode) && $stable(done)));

  assert_done_tracks_final_R8: assert property (@(posedge clk) disable iff (clear)
    done == (stateCode == 3'b101));

  assert_no_unused_code_R9: assert property (@(posedge clk) disable iff (clear)
    stateCode != 3'b110 && stateCode != 3'b111);
endmodule

bind coin_credit_fsm coin_credit_chk u_chk (
  .clk       (clk),
  .clear     (clear),
  .dime      (dime),
  .quarter   (quarter),
  .done      (done),
  .stateCode (stateCode)
);

// File: tb/sim_coin_credit_fsm.sv
module sim_coin_credit_fsm;
  logic       clk = 1'b0;
  logic       clear = 1'b1;
  logic       dime = 1'b0;
  logic       quarter = 1'b0;
  logic       done;
  logic [2:0] stateCode;
  int         applied = 0;
  int         miscompares = 0;
  bit         finished = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  coin_credit_fsm u0 (
    .clk       (clk),
    .clear     (clear),
    .dime      (dime),
    .quarter   (quarter),
    .done      (done),
    .stateCode (stateCode)
  );

  // entry: {req[3:0], clear, dime, quarter, expState[2:0], expDone}
  localparam int NV = 30;
  localparam logic [10:0] VEC [NV] = '{
    {4'd1, 3'b100, 3'b000, 1'b0},  // R1 clear
    {4'd2, 3'b010, 3'b001, 1'b0},  // R2 0->10
    {4'd2, 3'b010, 3'b010, 1'b0},  // R2 10->20
    {4'd2, 3'b010, 3'b100, 1'b0},  // R2 20->30
    {4'd7, 3'b000, 3'b100, 1'b0},  // R7 idle
    {4'd8, 3'b010, 3'b101, 1'b1},  // R8/R2 30->35, done rises
    {4'd4, 3'b001, 3'b101, 1'b1},  // R4 quarter at 35
    {4'd4, 3'b010, 3'b101, 1'b1},  // R4 dime at 35
    {4'd1, 3'b100, 3'b000, 1'b0},  // R1
    {4'd3, 3'b001, 3'b011, 1'b0},  // R3 0->25
    {4'd2, 3'b010, 3'b101, 1'b1},  // R2 25->35
    {4'd5, 3'b101, 3'b000, 1'b0},  // R5 clear+quarter
    {4'd6, 3'b011, 3'b011, 1'b0},  // R6 both from 0
    {4'd7, 3'b000, 3'b011, 1'b0},  // R7
    {4'd3, 3'b001, 3'b101, 1'b1},  // R3 25->35
    {4'd1, 3'b100, 3'b000, 1'b0},  // R1
    {4'd2, 3'b010, 3'b001, 1'b0},  // R2
    {4'd3, 3'b001, 3'b101, 1'b1},  // R3 10->35
    {4'd5, 3'b110, 3'b000, 1'b0},  // R5 clear+dime
    {4'd2, 3'b010, 3'b001, 1'b0},  // R2
    {4'd2, 3'b010, 3'b010, 1'b0},  // R2
    {4'd3, 3'b001, 3'b101, 1'b1},  // R3 20->35
    {4'd1, 3'b100, 3'b000, 1'b0},  // R1
    {4'd2, 3'b010, 3'b001, 1'b0},  // R2
    {4'd2, 3'b010, 3'b010, 1'b0},  // R2
    {4'd2, 3'b010, 3'b100, 1'b0},  // R2
    {4'd3, 3'b001, 3'b101, 1'b1},  // R3 30->35
    {4'd5, 3'b111, 3'b000, 1'b0},  // R5 clear+both
    {4'd2, 3'b010, 3'b001, 1'b0},  // R2
    {4'd6, 3'b011, 3'b101, 1'b1}   // R6 both from 10
  };

  task automatic check(input int req, input logic [2:0] expS, input logic expD);
    applied++;
    if (stateCode !== expS || done !== expD) begin
      miscompares++;
      $display("FAIL R%0d: state=%b done=%b expected state=%b done=%b",
               req, stateCode, done, expS, expD);
    end
  endtask

  task automatic step(input logic c, input logic d, input logic q);
    clear = c; dime = d; quarter = q;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    step(1'b1, 1'b0, 1'b0);
    check(1, 3'b000, 1'b0);   // R1 reset state
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][6], VEC[i][5], VEC[i][4]);
      check(int'(VEC[i][10:7]), VEC[i][3:1], VEC[i][0]);
    end
    // R1: clear held several cycles with coins offered
    for (int k = 0; k < 4; k++) begin
      step(1'b1, k[0], k[1]);
      check(1, 3'b000, 1'b0);
    end
    // R7: long idle after reaching 35, then clear
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    check(4, 3'b101, 1'b1);
    for (int k = 0; k < 5; k++) begin
      step(1'b0, 1'b0, 1'b0);
      check(7, 3'b101, 1'b1);
    end
    // R8: done low during 30, high only after completing coin
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    check(8, 3'b100, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    check(8, 3'b101, 1'b1);
    clear = 1'b0; dime = 1'b0; quarter = 1'b0;
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end
endmodule